// File: doc/BRIEF.md
# Speculative Exception Tag Tracker

This block is the register file that sits at the retirement stage of a processor that runs instructions speculatively. Every entry holds a data word and one exception tag bit. Each retiring instruction presents a speculative flag, up to two source register indices (each with a use flag), an optional destination index, its own PC, a fault indication and a result value.

A speculative instruction never raises anything. If it faults, it marks its destination as poisoned and stores its own PC there instead of a result. If it reads a poisoned register, it passes the poison and the stored PC on to its own destination. A fault here may be a program error or a transparent event such as a cache or translation miss; both are deferred the same way.

A non-speculative instruction that reads a poisoned register turns the deferred fault into a recovery request. The request carries the PC found in that register. A non-speculative instruction that faults on clean sources is reported at once with its own PC. Both requests are registered and appear one cycle after the instruction retires. A combinational peek port reads any entry's data and tag.

Top module: `spec_tag_tracker`

## Requirements
- R1: After reset every entry has tag 0 and data 0, and `excValid` and `recValid` are 0.
- R2: A speculative instruction with no tagged source and no fault writes `retResult` to its destination and clears the tag.
- R3: A speculative instruction with no tagged source that faults sets the destination tag and writes its own `retPc` as the data. This covers program faults and transparent events alike.
- R4: A speculative instruction with a tagged source sets the destination tag and copies that source's data into the destination, whether or not it also faults.
- R5: When both used sources are tagged, the data of source A is the PC that is propagated or reported.
- R6: A non-speculative instruction with no tagged source that faults raises `excValid` one cycle later with `excPc` equal to its own PC, and does not write its destination.
- R7: A non-speculative instruction with a tagged source raises `recValid` one cycle later with `recPc` equal to the tagged source's data, and leaves its destination unchanged.
- R8: A non-speculative instruction with clean sources and no fault writes `retResult` and clears the destination tag.
- R9: A source whose use flag is 0 is ignored, even if its register is tagged.
- R10: Speculative retirements and idle cycles raise neither request. `excValid` and `recValid` are never 1 together, and each is high for one cycle per causing instruction.
- R11: `peekData` and `peekTag` show the entry selected by `peekIdx` in the same cycle, including writes made at the preceding edge.
- R12: With `retDstUse` at 0, no entry is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| retValid | input | 1 | An instruction retires this cycle |
| retSpec | input | 1 | Retiring instruction was speculative |
| retSrcAUse | input | 1 | Source A is read |
| retSrcAIdx | input | IDX_W | Source A register index |
| retSrcBUse | input | 1 | Source B is read |
| retSrcBIdx | input | IDX_W | Source B register index |
| retDstUse | input | 1 | Instruction has a destination |
| retDstIdx | input | IDX_W | Destination register index |
| retPc | input | DATA_W | PC of the retiring instruction |
| retFault | input | 1 | Instruction faulted (program fault or transparent event) |
| retResult | input | DATA_W | Result value |
| peekIdx | input | IDX_W | Entry selected for the peek port |
| peekData | output | DATA_W | Data of the selected entry |
| peekTag | output | 1 | Exception tag of the selected entry |
| excValid | output | 1 | Immediate exception request |
| excPc | output | DATA_W | PC of the faulting non-speculative instruction |
| recValid | output | 1 | Recovery request for a deferred exception |
| recPc | output | DATA_W | PC at which recovery starts |

## Verification
The bench builds the block with 8 entries and 16-bit data. With so few entries, a short vector table can poison several registers, chain the poison through two levels, and then use every remaining entry as a clean source or destination. Together with 16-bit PCs, this lets each expected PC be picked by hand and kept distinct from every result value. Because of that, a wrong choice between own PC, propagated PC and result shows up as a different number at the peek port or on the request outputs.

// File: rtl/stt_pkg.sv
package stt_pkg;
  typedef enum logic [1:0] {
    WSRC_RESULT = 2'd0,
    WSRC_OWNPC  = 2'd1,
    WSRC_PROPPC = 2'd2
  } wsrc_e;

  typedef struct packed {
    logic  wrEn;
    logic  wrTag;
    wsrc_e wrSrc;
    logic  propFromB;
    logic  excFire;
    logic  recFire;
  } strobe_t;
endpackage

// File: rtl/stt_ctrl.sv
module stt_ctrl
  import stt_pkg::*;
(
  input  logic    retValid,
  input  logic    retSpec,
  input  logic    retFault,
  input  logic    retDstUse,
  input  logic    srcATagged,
  input  logic    srcBTagged,
  output strobe_t strb
);
  logic anyTagged;
  assign anyTagged = srcATagged | srcBTagged;

  always_comb begin
    strb = '0;
    strb.wrSrc = WSRC_RESULT;
    strb.propFromB = !srcATagged;
    if (retValid) begin
      if (retSpec) begin
        strb.wrEn = retDstUse;
        if (anyTagged) begin
          strb.wrTag = 1'b1;
          strb.wrSrc = WSRC_PROPPC;
        end else if (retFault) begin
          strb.wrTag = 1'b1;
          strb.wrSrc = WSRC_OWNPC;
        end
      end else begin
        if (anyTagged) begin
          strb.recFire = 1'b1;
        end else if (retFault) begin
          strb.excFire = 1'b1;
        end else begin
          strb.wrEn = retDstUse;
        end
      end
    end
  end
endmodule

// File: rtl/stt_datapath.sv
module stt_datapath
  import stt_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           strb,
  input  logic              srcAUse,
  input  logic [IDX_W-1:0]  srcAIdx,
  input  logic              srcBUse,
  input  logic [IDX_W-1:0]  srcBIdx,
  input  logic [IDX_W-1:0]  dstIdx,
  input  logic [DATA_W-1:0] pc,
  input  logic [DATA_W-1:0] result,
  input  logic [IDX_W-1:0]  peekIdx,
  output logic              srcATagged,
  output logic              srcBTagged,
  output logic [DATA_W-1:0] srcAData,
  output logic [DATA_W-1:0] srcBData,
  output logic [DATA_W-1:0] peekData,
  output logic              peekTag,
  output logic              excValid,
  output logic [DATA_W-1:0] excPc,
  output logic              recValid,
  output logic [DATA_W-1:0] recPc
);
  logic [DATA_W-1:0] regData [NUM_REGS];
  logic [NUM_REGS-1:0] regTag;
  logic [DATA_W-1:0] propPc;
  logic [DATA_W-1:0] wrData;

  assign srcAData   = regData[srcAIdx];
  assign srcBData   = regData[srcBIdx];
  assign srcATagged = srcAUse & regTag[srcAIdx];
  assign srcBTagged = srcBUse & regTag[srcBIdx];
  assign propPc     = strb.propFromB ? srcBData : srcAData;
  assign peekData   = regData[peekIdx];
  assign peekTag    = regTag[peekIdx];

  always_comb begin
    case (strb.wrSrc)
      WSRC_OWNPC:  wrData = pc;
      WSRC_PROPPC: wrData = propPc;
      default:     wrData = result;
    endcase
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_entry
    logic wrHit;
    assign wrHit = strb.wrEn && (dstIdx == IDX_W'(i));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        regData[i] <= '0;
        regTag[i]  <= 1'b0;
      end else if (wrHit) begin
        regData[i] <= wrData;
        regTag[i]  <= strb.wrTag;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      excValid <= 1'b0;
      excPc    <= '0;
      recValid <= 1'b0;
      recPc    <= '0;
    end else begin
      excValid <= strb.excFire;
      recValid <= strb.recFire;
      if (strb.excFire) excPc <= pc;
      if (strb.recFire) recPc <= propPc;
    end
  end
endmodule

// File: rtl/spec_tag_tracker.sv
module spec_tag_tracker
  import stt_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              retValid,
  input  logic              retSpec,
  input  logic              retSrcAUse,
  input  logic [IDX_W-1:0]  retSrcAIdx,
  input  logic              retSrcBUse,
  input  logic [IDX_W-1:0]  retSrcBIdx,
  input  logic              retDstUse,
  input  logic [IDX_W-1:0]  retDstIdx,
  input  logic [DATA_W-1:0] retPc,
  input  logic              retFault,
  input  logic [DATA_W-1:0] retResult,
  input  logic [IDX_W-1:0]  peekIdx,
  output logic [DATA_W-1:0] peekData,
  output logic              peekTag,
  output logic              excValid,
  output logic [DATA_W-1:0] excPc,
  output logic              recValid,
  output logic [DATA_W-1:0] recPc
);
  strobe_t strb;
  logic srcATagged, srcBTagged;
  logic [DATA_W-1:0] srcAData, srcBData;

  stt_ctrl u_ctrl (
    .retValid  (retValid),
    .retSpec   (retSpec),
    .retFault  (retFault),
    .retDstUse (retDstUse),
    .srcATagged(srcATagged),
    .srcBTagged(srcBTagged),
    .strb      (strb)
  );

  stt_datapath #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strb      (strb),
    .srcAUse   (retSrcAUse),
    .srcAIdx   (retSrcAIdx),
    .srcBUse   (retSrcBUse),
    .srcBIdx   (retSrcBIdx),
    .dstIdx    (retDstIdx),
    .pc        (retPc),
    .result    (retResult),
    .peekIdx   (peekIdx),
    .srcATagged(srcATagged),
    .srcBTagged(srcBTagged),
    .srcAData  (srcAData),
    .srcBData  (srcBData),
    .peekData  (peekData),
    .peekTag   (peekTag),
    .excValid  (excValid),
    .excPc     (excPc),
    .recValid  (recValid),
    .recPc     (recPc)
  );
endmodule

// File: rtl/spec_tag_tracker_chk.sv
module spec_tag_tracker_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              retValid,
  input logic              retSpec,
  input logic              retFault,
  input logic [DATA_W-1:0] retPc,
  input logic              srcATagged,
  input logic              srcBTagged,
  input logic [DATA_W-1:0] srcAData,
  input logic [DATA_W-1:0] srcBData,
  input logic              excValid,
  input logic [DATA_W-1:0] excPc,
  input logic              recValid,
  input logic [DATA_W-1:0] recPc
);
  // R10
  no_dual_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(excValid && recValid));

  // R10
  spec_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (retValid && retSpec) |=> (!excValid && !recValid));

  // R10
  idle_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !retValid |=> (!excValid && !recValid));

  // R5
  rec_from_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (retValid && !retSpec && srcATagged) |=> (recValid && recPc == $past(srcAData)));

  // R7
  rec_from_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (retValid && !retSpec && !srcATagged && srcBTagged) |=> (recValid && recPc == $past(srcBData)));

  // R6
  exc_own_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (retValid && !retSpec && !srcATagged && !srcBTagged && retFault) |=>
      (excValid && excPc == $past(retPc)));
endmodule

bind spec_tag_tracker spec_tag_tracker_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .retValid  (retValid),
  .retSpec   (retSpec),
  .retFault  (retFault),
  .retPc     (retPc),
  .srcATagged(srcATagged),
  .srcBTagged(srcBTagged),
  .srcAData  (srcAData),
  .srcBData  (srcBData),
  .excValid  (excValid),
  .excPc     (excPc),
  .recValid  (recValid),
  .recPc     (recPc)
);

// File: tb/tb_spec_tag_tracker.sv
`timescale 1ns/1ps
module tb_spec_tag_tracker;
  localparam int NUM_REGS = 8;
  localparam int DATA_W   = 16;
  localparam int IDX_W    = $clog2(NUM_REGS);
  localparam int NVEC     = 13;

  typedef struct packed {
    logic              spec;
    logic              ua;
    logic [IDX_W-1:0]  a;
    logic              ub;
    logic [IDX_W-1:0]  b;
    logic              ud;
    logic [IDX_W-1:0]  d;
    logic [DATA_W-1:0] pc;
    logic              fault;
    logic [DATA_W-1:0] res;
    logic              eExc;
    logic [DATA_W-1:0] eExcPc;
    logic              eRec;
    logic [DATA_W-1:0] eRecPc;
    logic [IDX_W-1:0]  cIdx;
    logic              cTag;
    logic [DATA_W-1:0] cData;
  } vec_t;

  // Fields: spec ua a ub b ud d pc fault res | eExc eExcPc eRec eRecPc | cIdx cTag cData
  localparam vec_t VECS [NVEC] = '{
    // R2 clean speculative write to r1
    '{1'b1,1'b0,3'd0,1'b0,3'd0,1'b1,3'd1,16'h0100,1'b0,16'h1111, 1'b0,16'h0,1'b0,16'h0, 3'd1,1'b0,16'h1111},
    // R3 speculative fault poisons r2 with own PC
    '{1'b1,1'b0,3'd0,1'b0,3'd0,1'b1,3'd2,16'h0104,1'b1,16'hDEAD, 1'b0,16'h0,1'b0,16'h0, 3'd2,1'b1,16'h0104},
    // R4 poison flows from r2 (source A) to r3
    '{1'b1,1'b1,3'd2,1'b0,3'd0,1'b1,3'd3,16'h0108,1'b0,16'hAAAA, 1'b0,16'h0,1'b0,16'h0, 3'd3,1'b1,16'h0104},
    // R3 transparent-event style fault poisons r4
    '{1'b1,1'b0,3'd0,1'b0,3'd0,1'b1,3'd4,16'h010C,1'b1,16'hBEEF, 1'b0,16'h0,1'b0,16'h0, 3'd4,1'b1,16'h010C},
    // R5 both sources tagged, A (r4) wins into r5
    '{1'b1,1'b1,3'd4,1'b1,3'd3,1'b1,3'd5,16'h0110,1'b1,16'hCCCC, 1'b0,16'h0,1'b0,16'h0, 3'd5,1'b1,16'h010C},
    // R4 tagged source B (r2) propagates into r6
    '{1'b1,1'b1,3'd1,1'b1,3'd2,1'b1,3'd6,16'h0114,1'b0,16'h6666, 1'b0,16'h0,1'b0,16'h0, 3'd6,1'b1,16'h0104},
    // R9 tagged r2 on unused source A is ignored
    '{1'b1,1'b0,3'd2,1'b1,3'd1,1'b1,3'd7,16'h0118,1'b0,16'h7777, 1'b0,16'h0,1'b0,16'h0, 3'd7,1'b0,16'h7777},
    // R8 non-speculative clean write to r1
    '{1'b0,1'b1,3'd1,1'b1,3'd7,1'b1,3'd1,16'h011C,1'b0,16'h2222, 1'b0,16'h0,1'b0,16'h0, 3'd1,1'b0,16'h2222},
    // R6 non-speculative fault, r0 not written
    '{1'b0,1'b1,3'd1,1'b0,3'd0,1'b1,3'd0,16'h0200,1'b1,16'h9999, 1'b1,16'h0200,1'b0,16'h0, 3'd0,1'b0,16'h0000},
    // R7 R5 recovery with A (r5) chosen, r7 unchanged
    '{1'b0,1'b1,3'd5,1'b1,3'd6,1'b1,3'd7,16'h0204,1'b0,16'h1234, 1'b0,16'h0,1'b1,16'h010C, 3'd7,1'b0,16'h7777},
    // R7 recovery via source B (r6), r0 unchanged
    '{1'b0,1'b1,3'd1,1'b1,3'd6,1'b1,3'd0,16'h0208,1'b1,16'h4321, 1'b0,16'h0,1'b1,16'h0104, 3'd0,1'b0,16'h0000},
    // R8 non-speculative write clears the tag of r2
    '{1'b0,1'b1,3'd1,1'b0,3'd0,1'b1,3'd2,16'h020C,1'b0,16'h5555, 1'b0,16'h0,1'b0,16'h0, 3'd2,1'b0,16'h5555},
    // R12 no destination: r3 keeps its poison
    '{1'b1,1'b0,3'd0,1'b0,3'd0,1'b0,3'd3,16'h0300,1'b1,16'hFFFF, 1'b0,16'h0,1'b0,16'h0, 3'd3,1'b1,16'h0104}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic retValid, retSpec, retSrcAUse, retSrcBUse, retDstUse, retFault;
  logic [IDX_W-1:0] retSrcAIdx, retSrcBIdx, retDstIdx, peekIdx;
  logic [DATA_W-1:0] retPc, retResult;
  logic [DATA_W-1:0] peekData, excPc, recPc;
  logic peekTag, excValid, recValid;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  spec_tag_tracker #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) dut (
    .clk(clk), .rst_n(rst_n),
    .retValid(retValid), .retSpec(retSpec),
    .retSrcAUse(retSrcAUse), .retSrcAIdx(retSrcAIdx),
    .retSrcBUse(retSrcBUse), .retSrcBIdx(retSrcBIdx),
    .retDstUse(retDstUse), .retDstIdx(retDstIdx),
    .retPc(retPc), .retFault(retFault), .retResult(retResult),
    .peekIdx(peekIdx), .peekData(peekData), .peekTag(peekTag),
    .excValid(excValid), .excPc(excPc),
    .recValid(recValid), .recPc(recPc)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idleInputs();
    retValid = 1'b0; retSpec = 1'b0; retSrcAUse = 1'b0; retSrcBUse = 1'b0;
    retDstUse = 1'b0; retFault = 1'b0; retSrcAIdx = '0; retSrcBIdx = '0;
    retDstIdx = '0; retPc = '0; retResult = '0;
  endtask

  task automatic checkClean(input string req);
    for (int r = 0; r < NUM_REGS; r++) begin
      peekIdx = IDX_W'(r);
      #0.5;
      check(req, "entry tag", {31'b0, peekTag}, 32'd0);
      check(req, "entry data", {16'b0, peekData}, 32'd0);
    end
    check(req, "excValid", {31'b0, excValid}, 32'd0);
    check(req, "recValid", {31'b0, recValid}, 32'd0);
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    idleInputs();
    peekIdx = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checkClean("R1");

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      retValid   = 1'b1;
      retSpec    = VECS[i].spec;
      retSrcAUse = VECS[i].ua;  retSrcAIdx = VECS[i].a;
      retSrcBUse = VECS[i].ub;  retSrcBIdx = VECS[i].b;
      retDstUse  = VECS[i].ud;  retDstIdx  = VECS[i].d;
      retPc      = VECS[i].pc;  retFault   = VECS[i].fault;
      retResult  = VECS[i].res;
      @(negedge clk);
      retValid = 1'b0;
      check("R6 R10", $sformatf("vec%0d excValid", i), {31'b0, excValid}, {31'b0, VECS[i].eExc});
      if (VECS[i].eExc) check("R6", $sformatf("vec%0d excPc", i), {16'b0, excPc}, {16'b0, VECS[i].eExcPc});
      check("R7 R10", $sformatf("vec%0d recValid", i), {31'b0, recValid}, {31'b0, VECS[i].eRec});
      if (VECS[i].eRec) check("R7", $sformatf("vec%0d recPc", i), {16'b0, recPc}, {16'b0, VECS[i].eRecPc});
      // R11 peek reflects the write made at the preceding edge
      peekIdx = VECS[i].cIdx;
      #0.5;
      check("R11", $sformatf("vec%0d tag", i), {31'b0, peekTag}, {31'b0, VECS[i].cTag});
      check("R11", $sformatf("vec%0d data", i), {16'b0, peekData}, {16'b0, VECS[i].cData});
    end

    // R10 request pulses drop on the idle cycle after a recovery request
    @(negedge clk);
    retValid = 1'b1; retSpec = 1'b0; retSrcAUse = 1'b1; retSrcAIdx = 3'd3;
    retSrcBUse = 1'b0; retDstUse = 1'b1; retDstIdx = 3'd1; retPc = 16'h0400; retFault = 1'b0;
    @(negedge clk);
    retValid = 1'b0;
    check("R7", "rec via r3", {31'b0, recValid}, 32'd1);
    check("R7", "rec pc via r3", {16'b0, recPc}, 32'h0104);
    @(negedge clk);
    check("R10", "rec pulse ends", {31'b0, recValid}, 32'd0);
    check("R10", "exc stays low", {31'b0, excValid}, 32'd0);
    peekIdx = 3'd1;
    #0.5;
    check("R7", "r1 kept", {16'b0, peekData}, 32'h2222);

    // R1 mid-run reset clears all poisoned entries
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checkClean("R1");

    finishRun();
  end
endmodule